// File: doc/BRIEF.md
# Pin-Configurable Clock Bank Gate and Profile Selector

The block takes four free-running source clocks, one per output bank, and drives eight clock outputs, two per bank. Five general control pins steer it. Each pin gets its role from a static function vector that is set at build time: master enable, the enable of one bank, profile reset, or one of two profile-select bits. All enables are active low. A bank that is disabled holds both of its outputs low. Starting and stopping a bank never cuts a pulse short.

The active frequency profile is a small register. It changes only when the reset function is held high for a minimum number of system-clock cycles and then released. When that release happens, the block samples the select function. While the new profile takes over, the block squelches every output, so downstream logic never sees a clock that belongs to a half-applied profile. A separate mode input chooses between two-profile selection (one select bit) and three-profile selection (two select bits).

Top module: `clkbank_ctrl`

## Requirements
- R1: The role of pin p is given by the 4-bit field `pin_func[4p+3:4p]`. The codes are: 0 = none, 1 = master enable, 2 = profile reset, 3 = select bit 0, 4 = select bit 1, 5+b = enable of bank b, and any other code = none. The select codes take effect only on pins 0 to 2; on pins 3 and 4 they count as none. When several pins share a role, the role's value is the OR of those pins.
- R2: While the master-enable role is high, all eight outputs are low. While it is low, the banks follow their own enables.
- R3: While the enable role of bank b is high, outputs 2b and 2b+1 are low. The other banks keep running.
- R4: Every high pulse on an output lasts exactly half of its bank's source period. Every low pulse lasts at least that long. This holds across every start, stop and squelch.
- R5: A role that no pin holds reads as its inactive value. Enables read as asserted (low), reset reads as low, select bit 1 reads as 0, and select bit 0 reads as 1 in three-profile mode and as 0 in two-profile mode. The net effect is that an unassigned select picks profile 1.
- R6: In three-profile mode (`three_prof`=1), select {bit1,bit0} = 01, 10 or 11 loads `profile` = 1, 2 or 3. The code 00 is reserved and leaves `profile` unchanged.
- R7: In two-profile mode (`three_prof`=0), select bit 0 = 0 loads `profile` = 1 and select bit 0 = 1 loads `profile` = 2.
- R8: A change on the select pins has no effect on `profile` until a qualified reset is released. The new value then appears within 4 system-clock cycles of the release reaching the block.
- R9: A reset held for fewer than RST_MIN_CYC consecutive system-clock cycles is ignored. It changes neither the profile nor the outputs.
- R10: Once a reset has been held for RST_MIN_CYC cycles, all outputs are squelched low. The squelch lasts until SQUELCH_CYC system-clock cycles after the release, and then the enabled banks resume.
- R11: While `sys_rst` is high, the block sets `profile` to 1 and clears any squelch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock for pin sampling and profile control |
| sys_rst | input | 1 | Synchronous active-high block reset |
| bank_clk | input | NUM_BANKS | Source clock of each bank |
| ctl_pin | input | NUM_PINS | Raw control pins, asynchronous |
| pin_func | input | NUM_PINS*4 | Static role code of each pin |
| three_prof | input | 1 | 1 = three-profile selection, 0 = two-profile selection |
| clk_out | output | NUM_BANKS*OUTS_PER_BANK | Gated clock outputs; bank b drives bits 2b and 2b+1 |
| profile | output | 2 | Active profile number (1 to 3) |

## Verification
The bench sweeps every pin against every bank-enable role and against the master role. It shows that exactly the addressed pair stops and that any pin can hold any gating role. Every pair of distinct pins is tried as the two select bits, with all four select codes, under long reset pulses. This separates the decode of each code, the handling of the reserved value and the ignoring of select changes between resets. Short pulses, two-profile mode and a select role placed on a pin that may not hold it cover the reset filter and the defaults. A pulse-width monitor on all eight outputs watches every start, stop and squelch for runt or shortened pulses.

// File: rtl/clkbank_pkg.sv
package clkbank_pkg;
  // width of one pin's role code
  localparam int FN_W = 4;

  // role codes; bank b enable uses FN_BANK_BASE + b
  localparam int FN_NONE      = 0;
  localparam int FN_MASTER    = 1;
  localparam int FN_RESET     = 2;
  localparam int FN_SEL0      = 3;
  localparam int FN_SEL1      = 4;
  localparam int FN_BANK_BASE = 5;

  // decoded global roles (levels as seen after synchronisation)
  typedef struct packed {
    logic master_n;
    logic rst_req;
    logic sel1;
    logic sel0;
  } ctl_roles_t;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/pin_role_map.sv
module pin_role_map
  import clkbank_pkg::*;
#(
  parameter int NUM_PINS  = 5,
  parameter int NUM_BANKS = 4,
  parameter int SEL_PINS  = 3
) (
  input  logic [NUM_PINS-1:0]      pin_s,
  input  logic [NUM_PINS*FN_W-1:0] pin_func,
  input  logic                     three_prof,
  output ctl_roles_t               roles,
  output logic [NUM_BANKS-1:0]     bank_n
);
  logic [FN_W-1:0]      code;
  logic                 has_m, has_r, has_s0, has_s1;
  logic                 val_m, val_r, val_s0, val_s1;
  logic [NUM_BANKS-1:0] has_b, val_b;

  always_comb begin
    has_m = 1'b0; has_r = 1'b0; has_s0 = 1'b0; has_s1 = 1'b0;
    val_m = 1'b0; val_r = 1'b0; val_s0 = 1'b0; val_s1 = 1'b0;
    has_b = '0;   val_b = '0;
    code  = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      code = pin_func[p*FN_W +: FN_W];
      if (code == FN_W'(FN_MASTER)) begin
        has_m = 1'b1; val_m = val_m | pin_s[p];
      end
      if (code == FN_W'(FN_RESET)) begin
        has_r = 1'b1; val_r = val_r | pin_s[p];
      end
      // select roles are only honoured on the low-numbered pins
      if (code == FN_W'(FN_SEL0) && p < SEL_PINS) begin
        has_s0 = 1'b1; val_s0 = val_s0 | pin_s[p];
      end
      if (code == FN_W'(FN_SEL1) && p < SEL_PINS) begin
        has_s1 = 1'b1; val_s1 = val_s1 | pin_s[p];
      end
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (code == FN_W'(FN_BANK_BASE + b)) begin
          has_b[b] = 1'b1; val_b[b] = val_b[b] | pin_s[p];
        end
      end
    end
    // unassigned roles fall back to their inactive level
    roles.master_n = has_m  ? val_m  : 1'b0;
    roles.rst_req  = has_r  ? val_r  : 1'b0;
    roles.sel1     = has_s1 ? val_s1 : 1'b0;
    roles.sel0     = has_s0 ? val_s0 : three_prof;
    for (int b = 0; b < NUM_BANKS; b++) bank_n[b] = has_b[b] ? val_b[b] : 1'b0;
  end
endmodule

// File: rtl/profile_ctrl.sv
module profile_ctrl #(
  parameter int RST_MIN_CYC = 20,
  parameter int SQUELCH_CYC = 200000
) (
  input  logic       sys_clk,
  input  logic       sys_rst,
  input  logic       rst_req,
  input  logic       sel0,
  input  logic       sel1,
  input  logic       three_prof,
  output logic [1:0] profile,
  output logic       squelch,
  output logic       qual,
  output logic       rel_pulse
);
  localparam int CNT_W = $clog2(RST_MIN_CYC + 1);
  localparam int SQ_W  = $clog2(SQUELCH_CYC + 1);

  logic [CNT_W-1:0] hold_cnt;
  logic [SQ_W-1:0]  sq_cnt;
  logic [1:0]       next_prof;
  logic             reserved;

  assign rel_pulse = qual & ~rst_req;
  assign squelch   = qual | (sq_cnt != '0);
  assign reserved  = three_prof & ~sel1 & ~sel0;
  assign next_prof = three_prof ? {sel1, sel0} : (sel0 ? 2'd2 : 2'd1);

  always_ff @(posedge sys_clk) begin
    if (sys_rst) begin
      hold_cnt <= '0;
      qual     <= 1'b0;
      sq_cnt   <= '0;
      profile  <= 2'd1;
    end else begin
      // pulse-width qualification: N consecutive high cycles
      if (rst_req) begin
        if (!qual) begin
          if (hold_cnt == CNT_W'(RST_MIN_CYC - 1)) qual <= 1'b1;
          else hold_cnt <= hold_cnt + 1'b1;
        end
      end else begin
        hold_cnt <= '0;
      end
      // release of a qualified reset: load profile, start squelch tail
      if (rel_pulse) begin
        qual   <= 1'b0;
        sq_cnt <= SQ_W'(SQUELCH_CYC);
        if (!reserved) profile <= next_prof;
      end else if (sq_cnt != '0) begin
        sq_cnt <= sq_cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/bank_gate.sv
module bank_gate #(
  parameter int SYNC_STAGES = 2,
  parameter int OUTS        = 2
) (
  input  logic            sys_rst,
  input  logic            en_req,
  input  logic            bank_clk,
  output logic [OUTS-1:0] gclk
);
  logic [SYNC_STAGES-1:0] en_sync;
  logic                   en_lat;

  // bring the system-domain request into the bank clock domain
  always_ff @(posedge bank_clk) begin
    if (sys_rst) en_sync <= '0;
    else         en_sync <= {en_sync[SYNC_STAGES-2:0], en_req};
  end

  // transparent while the clock is low: the enable only moves in the low phase
  always_latch begin
    if (!bank_clk) en_lat <= en_sync[SYNC_STAGES-1];
  end

  for (genvar i = 0; i < OUTS; i++) begin : g_out
    assign gclk[i] = bank_clk & en_lat;
  end
endmodule

// File: rtl/clkbank_ctrl.sv
module clkbank_ctrl
  import clkbank_pkg::*;
#(
  parameter int NUM_PINS      = 5,
  parameter int NUM_BANKS     = 4,
  parameter int OUTS_PER_BANK = 2,
  parameter int SEL_PINS      = 3,
  parameter int SYNC_STAGES   = 2,
  parameter int RST_MIN_CYC   = 20,
  parameter int SQUELCH_CYC   = 200000
) (
  input  logic                               sys_clk,
  input  logic                               sys_rst,
  input  logic [NUM_BANKS-1:0]               bank_clk,
  input  logic [NUM_PINS-1:0]                ctl_pin,
  input  logic [NUM_PINS*FN_W-1:0]           pin_func,
  input  logic                               three_prof,
  output logic [NUM_BANKS*OUTS_PER_BANK-1:0] clk_out,
  output logic [1:0]                         profile
);
  logic [NUM_PINS-1:0]  pin_s;
  ctl_roles_t           roles;
  logic [NUM_BANKS-1:0] bank_n;
  logic [NUM_BANKS-1:0] en_req;
  logic                 squelch_w, qual_w, rel_pulse;

  pin_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(sys_clk), .rst(sys_rst), .d(ctl_pin), .q(pin_s)
  );

  pin_role_map #(.NUM_PINS(NUM_PINS), .NUM_BANKS(NUM_BANKS), .SEL_PINS(SEL_PINS)) u_map (
    .pin_s(pin_s), .pin_func(pin_func), .three_prof(three_prof),
    .roles(roles), .bank_n(bank_n)
  );

  profile_ctrl #(.RST_MIN_CYC(RST_MIN_CYC), .SQUELCH_CYC(SQUELCH_CYC)) u_prof (
    .sys_clk(sys_clk), .sys_rst(sys_rst), .rst_req(roles.rst_req),
    .sel0(roles.sel0), .sel1(roles.sel1), .three_prof(three_prof),
    .profile(profile), .squelch(squelch_w), .qual(qual_w), .rel_pulse(rel_pulse)
  );

  // registered per-bank run request in the system domain
  always_ff @(posedge sys_clk) begin
    if (sys_rst) en_req <= '0;
    else begin
      for (int b = 0; b < NUM_BANKS; b++)
        en_req[b] <= ~squelch_w & ~roles.master_n & ~bank_n[b];
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    bank_gate #(.SYNC_STAGES(SYNC_STAGES), .OUTS(OUTS_PER_BANK)) u_gate (
      .sys_rst(sys_rst), .en_req(en_req[b]), .bank_clk(bank_clk[b]),
      .gclk(clk_out[b*OUTS_PER_BANK +: OUTS_PER_BANK])
    );
  end
endmodule

// File: rtl/clkbank_ctrl_chk.sv
module clkbank_ctrl_chk #(
  parameter int NUM_BANKS   = 4,
  parameter int RST_MIN_CYC = 20,
  parameter int SQUELCH_CYC = 200000
) (
  input logic                 sys_clk,
  input logic                 sys_rst,
  input logic [1:0]           profile,
  input logic                 squelch,
  input logic                 qual,
  input logic                 rel_pulse,
  input logic                 rst_req,
  input logic [NUM_BANKS-1:0] en_req
);
  int rst_run;
  int sq_run;

  always_ff @(posedge sys_clk) begin
    if (sys_rst) begin
      rst_run <= 0;
      sq_run  <= 0;
    end else begin
      rst_run <= rst_req ? ((rst_run < RST_MIN_CYC + 8) ? rst_run + 1 : rst_run) : 0;
      sq_run  <= (squelch && !qual) ? sq_run + 1 : 0;
    end
  end

  // R11: block reset restores profile 1
  assert_rst_profile_R11: assert property (@(posedge sys_clk)
    sys_rst |=> profile == 2'd1);

  // R6: the reserved code is never loaded
  assert_profile_legal_R6: assert property (@(posedge sys_clk) disable iff (sys_rst)
    profile != 2'd0);

  // R8: profile moves only on a qualified release
  assert_profile_hold_R8: assert property (@(posedge sys_clk) disable iff (sys_rst)
    !rel_pulse |=> $stable(profile));

  // R9: qualification needs the full minimum hold
  assert_min_width_R9: assert property (@(posedge sys_clk) disable iff (sys_rst)
    $rose(qual) |-> rst_run >= RST_MIN_CYC);

  // R10: squelch withdraws every bank request
  assert_squelch_gates_R10: assert property (@(posedge sys_clk) disable iff (sys_rst)
    squelch |=> en_req == '0);

  // R10: the squelch tail after release is bounded
  assert_squelch_bound_R10: assert property (@(posedge sys_clk) disable iff (sys_rst)
    sq_run <= SQUELCH_CYC);
endmodule

bind clkbank_ctrl clkbank_ctrl_chk #(
  .NUM_BANKS(NUM_BANKS), .RST_MIN_CYC(RST_MIN_CYC), .SQUELCH_CYC(SQUELCH_CYC)
) u_chk (
  .sys_clk(sys_clk), .sys_rst(sys_rst), .profile(profile), .squelch(squelch_w),
  .qual(qual_w), .rel_pulse(rel_pulse), .rst_req(roles.rst_req), .en_req(en_req)
);

// File: tb/clkbank_ctrl_test.sv
module clkbank_ctrl_test;
  localparam int CLK_PERIOD = 20;
  localparam int NP   = 5;
  localparam int NB   = 4;
  localparam int NO   = 8;
  localparam int RMIN = 20;
  localparam int SQ   = 64;
  // role codes (R1)
  localparam int F_MASTER = 1, F_RST = 2, F_SEL0 = 3, F_SEL1 = 4, F_BANK = 5;

  logic          sys_clk = 1'b0;
  logic          sys_rst = 1'b1;
  wire  [NB-1:0] bank_clk;
  logic [NP-1:0] ctl_pin = '0;
  logic [19:0]   pin_func = '0;
  logic          three_prof = 1'b1;
  wire  [NO-1:0] clk_out;
  wire  [1:0]    profile;

  int n_vec = 0;
  int n_bad = 0;
  logic [NO-1:0] seen_hi, seen_lo;
  int mon_bad [NO];
  int mon_cnt [NO];

  clkbank_ctrl #(.RST_MIN_CYC(RMIN), .SQUELCH_CYC(SQ)) uut (
    .sys_clk(sys_clk), .sys_rst(sys_rst), .bank_clk(bank_clk), .ctl_pin(ctl_pin),
    .pin_func(pin_func), .three_prof(three_prof), .clk_out(clk_out), .profile(profile)
  );

  always #(CLK_PERIOD/2) sys_clk = ~sys_clk;

  function automatic int half_of(int b);
    return 14 + 4*b;   // all edges land on even times
  endfunction

  for (genvar b = 0; b < NB; b++) begin : g_src
    logic c = 1'b0;
    initial forever #(half_of(b)) c = ~c;
    assign bank_clk[b] = c;
  end

  // pulse-width monitor per output (R4)
  for (genvar i = 0; i < NO; i++) begin : g_mon
    longint t_r = 0, t_f = 0;
    bit     had_f = 1'b0;
    int     bad = 0, cnt = 0;
    always @(posedge clk_out[i]) begin
      if (had_f && ($time - t_f) < half_of(i/2)) bad++;
      t_r = $time;
    end
    always @(negedge clk_out[i]) begin
      if (($time - t_r) != half_of(i/2)) bad++;
      cnt++;
      t_f = $time;
      had_f = 1'b1;
    end
    assign mon_bad[i] = bad;
    assign mon_cnt[i] = cnt;
  end

  function automatic logic [19:0] fmap(int p, int code);
    logic [19:0] v = '0;
    v[p*4 +: 4] = 4'(code);
    return v;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge sys_clk);
  endtask

  // sample outputs at odd times, away from every clock edge
  task automatic observe(int n);
    seen_hi = '0; seen_lo = '0;
    #1;
    repeat (n) begin
      seen_hi |= clk_out;
      seen_lo |= ~clk_out;
      #2;
    end
    #1;
  endtask

  task automatic pulse(int p, int n);
    @(negedge sys_clk) ctl_pin[p] = 1'b1;
    cyc(n);
    ctl_pin[p] = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    int exp_prof;
    logic [NO-1:0] mask;
    cyc(10);
    sys_rst = 1'b0;
    cyc(20);
    // R11 reset state, R5 default enables with nothing assigned
    chk(profile == 2'd1, "R11", "profile after reset", profile, 1);
    observe(200);
    chk(seen_hi == '1 && seen_lo == '1, "R5", "unassigned enables run all", seen_hi, 255);

    // R3 / R1: every pin as every bank enable
    for (int p = 0; p < NP; p++) begin
      for (int b = 0; b < NB; b++) begin
        pin_func = fmap(p, F_BANK + b);
        mask = 8'b11 << (2*b);
        @(negedge sys_clk) ctl_pin[p] = 1'b1;
        cyc(20); observe(200);
        chk(seen_hi == ~mask && (seen_lo & ~mask) == ~mask, "R3", "bank disabled",
            seen_hi, int'(~mask));
        @(negedge sys_clk) ctl_pin[p] = 1'b0;
        cyc(20); observe(200);
        chk(seen_hi == '1, "R3", "bank re-enabled", seen_hi, 255);
      end
    end
    // R2: master enable on each pin
    for (int p = 0; p < NP; p++) begin
      pin_func = fmap(p, F_MASTER);
      @(negedge sys_clk) ctl_pin[p] = 1'b1;
      cyc(20); observe(200);
      chk(seen_hi == '0, "R2", "master off", seen_hi, 0);
      @(negedge sys_clk) ctl_pin[p] = 1'b0;
      cyc(20); observe(200);
      chk(seen_hi == '1, "R2", "master on", seen_hi, 255);
    end
    // R1: two pins on bank 1 combine by OR
    pin_func = fmap(0, F_BANK + 1) | fmap(3, F_BANK + 1);
    @(negedge sys_clk) ctl_pin[3] = 1'b1;
    cyc(20); observe(200);
    chk(seen_hi == 8'hF3, "R1", "shared role OR", seen_hi, 243);
    @(negedge sys_clk) ctl_pin[3] = 1'b0;

    // R6/R8/R10: three-profile sweep over select pin pairs
    exp_prof = 1;
    three_prof = 1'b1;
    for (int sa = 0; sa < 3; sa++) begin
      for (int sb = 0; sb < 3; sb++) begin
        if (sa != sb) begin
          int rp = 3 + ((sa + sb) % 2);
          pin_func = fmap(sa, F_SEL0) | fmap(sb, F_SEL1) | fmap(rp, F_RST);
          for (int k = 0; k < 4; k++) begin
            int code = (k + 2) % 4;
            @(negedge sys_clk) begin
              ctl_pin[sa] = code[0];
              ctl_pin[sb] = code[1];
            end
            cyc(30);
            chk(int'(profile) == exp_prof, "R8", "select ignored before reset", profile, exp_prof);
            pulse(rp, RMIN + 8);
            cyc(10); observe(200);
            chk(seen_hi == '0, "R10", "squelched after reset", seen_hi, 0);
            cyc(60);
            if (code != 0) exp_prof = code;
            chk(int'(profile) == exp_prof, "R6", "three-profile decode", profile, exp_prof);
            observe(200);
            chk(seen_hi == '1, "R10", "outputs resume", seen_hi, 255);
          end
          // R9: short pulse filtered
          @(negedge sys_clk) begin
            ctl_pin[sa] = ~exp_prof[0];
            ctl_pin[sb] = 1'b1;
          end
          pulse(rp, RMIN - 4);
          observe(200);
          chk(seen_hi == '1, "R9", "no squelch on short reset", seen_hi, 255);
          cyc(20);
          chk(int'(profile) == exp_prof, "R9", "short reset ignored", profile, exp_prof);
          @(negedge sys_clk) ctl_pin = '0;
        end
      end
    end

    // R7: two-profile mode, select bit on each allowed pin
    three_prof = 1'b0;
    for (int p = 0; p < 3; p++) begin
      pin_func = fmap(p, F_SEL0) | fmap(4, F_RST);
      for (int v = 1; v >= 0; v--) begin
        @(negedge sys_clk) ctl_pin[p] = v[0];
        pulse(4, RMIN + 4);
        cyc(SQ + 20);
        chk(int'(profile) == (v == 1 ? 2 : 1), "R7", "two-profile decode", profile, v == 1 ? 2 : 1);
      end
      @(negedge sys_clk) ctl_pin[p] = 1'b1;
      pulse(4, RMIN + 4);
      cyc(SQ + 20);
      @(negedge sys_clk) ctl_pin[p] = 1'b0;
    end
    chk(profile == 2'd2, "R7", "two-profile holds 2", profile, 2);

    // R1/R5: select role on pin 3 is not honoured; defaults give profile 1
    three_prof = 1'b1;
    pin_func = fmap(3, F_SEL1) | fmap(4, F_RST);
    @(negedge sys_clk) ctl_pin[3] = 1'b1;
    pulse(4, RMIN + 4);
    cyc(SQ + 20);
    chk(profile == 2'd1, "R5", "select default on restricted pin", profile, 1);
    @(negedge sys_clk) ctl_pin = '0;
    cyc(40);

    // R4: clean pulses throughout every start, stop and squelch
    for (int i = 0; i < NO; i++) begin
      chk(mon_bad[i] == 0 && mon_cnt[i] > 0, "R4", $sformatf("pulse widths out%0d", i),
          mon_bad[i], 0);
    end
    finish_run();
  end
endmodule